// File: doc/BRIEF.md
# Standby Entry and Wake Sequencer

This block sequences a low-power standby state for a small microcontroller. A one-cycle sleep strobe from the CPU is accepted only when the configuration allows it. After one entry cycle, during which a wake event can still cancel the request, the block turns off the CPU clock, the peripheral clocks and the oscillator enable. The external bus outputs are then either released to high impedance or held at their last values, as chosen by a configuration bit.

Wake events come from the non-maskable line, a bank of external interrupt lines, a small group of auxiliary interrupt sources, or the voltage monitor. Each interrupt line is qualified by its own enable, a CPU mask, a DMA-trigger routing flag and a higher-priority-pending flag. An interrupt wake turns the oscillator back on straight away. It then keeps the clocks off for a settle time counted on a free-running low-frequency reference tick. After that it restores the clocks and issues a one-cycle interrupt-wake pulse. A voltage-monitor reset restores the oscillator and the clocks at once. It holds the block until the monitor releases, then issues a one-cycle reset-wake pulse. The reset pin and the standby pin both force the block back to its run state asynchronously.

Top module: `lpwr_standby_ctrl`

## Requirements
- R1: A sleep strobe is accepted when standby enable is 1, deep-standby select is 0 and watchdog mode is 0. The next cycle is an entry cycle in which all clocks still run, and the cycle after that is standby.
- R2: While watchdog mode is 1, a sleep strobe leaves the oscillator and all clocks running.
- R3: While deep-standby select is 1, or standby enable is 0, a sleep strobe leaves the oscillator and all clocks running.
- R4: In standby, the oscillator enable, the CPU clock enable and the peripheral clock enable are all 0. A clock enable is never 1 while the oscillator enable is 0.
- R5: The bus-keep bit is captured when the strobe is accepted. While the clocks are off (standby and settle), bus_hiz_o is 1 when the captured bit is 0, and bus_hold_o is 1 when it is 1. The two outputs are never both 1, and both are 0 while the clocks run.
- R6: An external interrupt line wakes the block only when its request, its enable bit is 1, its CPU mask bit is 0, its DMA-trigger bit is 0 and the higher-priority-pending input is 0. An auxiliary source wakes it when its request and its enable are 1. The non-maskable line always wakes it.
- R7: On an interrupt wake, the oscillator enable returns in the next cycle. The clocks then stay off for exactly 2^min(S,15) reference ticks, where S is the 5-bit settle field captured at acceptance (default counter width 16). The counter advances only on cycles with a reference tick.
- R8: When the settle count completes, the clocks return, and in that same cycle irq_wake_o is 1 for exactly one cycle.
- R9: A voltage-monitor reset during standby or settle turns the oscillator and clocks on in the next cycle. The block stays there while the monitor is asserted. In the cycle after it releases, rst_wake_o is 1 for one cycle, and irq_wake_o stays 0.
- R10: A wake event or voltage-monitor reset during the entry cycle returns the block to run. The clocks are never gated and no wake pulse is issued.
- R11: A low level on the reset pin or on the standby pin forces the run state at once. The oscillator and clocks are on, the bus controls are 0 and there are no pulses, whatever the current state.
- R12: In run, wake inputs and the voltage-monitor input have no effect. No pulse appears and the clocks stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Reset pin, active low, asynchronous |
| stby_pin_n_i | input | 1 | Standby pin, active low, asynchronous |
| lf_tick_i | input | 1 | One-cycle tick from the free-running low-frequency reference |
| sleep_req_i | input | 1 | Sleep request strobe from the CPU |
| cfg_stby_en_i | input | 1 | Standby enable bit |
| cfg_deep_i | input | 1 | Deep-standby select bit |
| cfg_bus_keep_i | input | 1 | 1 holds bus outputs, 0 releases them to high impedance |
| cfg_settle_sel_i | input | 5 | Oscillator settle select |
| wdt_mode_i | input | 1 | Watchdog running in watchdog-timer mode |
| nmi_i | input | 1 | Non-maskable wake request |
| irq_req_i | input | 12 | External interrupt requests |
| irq_en_i | input | 12 | Per-line interrupt enable |
| irq_cpu_mask_i | input | 12 | Per-line CPU-side mask |
| irq_dma_trig_i | input | 12 | Per-line routing as DMA trigger |
| hipri_pend_i | input | 1 | A higher-priority interrupt is pending |
| aux_req_i | input | 3 | Auxiliary wake requests (timer, voltage detect, USB suspend/resume) |
| aux_en_i | input | 3 | Auxiliary wake enables |
| vmon_rst_i | input | 1 | Voltage-monitor reset, high while supply is low |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | 1 | Peripheral clock gate enable |
| bus_hiz_o | output | 1 | Put address bus and bus controls in high impedance |
| bus_hold_o | output | 1 | Hold address bus and bus controls at last values |
| irq_wake_o | output | 1 | One-cycle pulse: start interrupt exception handling |
| rst_wake_o | output | 1 | One-cycle pulse: start reset exception handling |

## Verification
The assertions check these properties on every cycle:
- the state stays one-hot;
- watchdog mode, deep standby or a cleared enable never lets the sequencer reach the entry cycle;
- a wake during the entry cycle always returns to run;
- the settle counter stays at or below its terminal value and holds when no tick arrives;
- each wake pulse comes from the right predecessor state;
- no clock enable is on without the oscillator, and the two bus controls are never both on.

Only the bench's scenarios can show the rest:
- the exact settle length for each field value, including the clipped top value;
- the full qualification matrix of each interrupt line;
- that the configuration is captured at acceptance;
- the asynchronous effect of the two pins.

// File: rtl/lpwr_pkg.sv
`timescale 1ns/1ps
package lpwr_pkg;

   // One-hot sequencer states
   typedef enum logic [5:0] {
      ST_RUN    = 6'b000001,
      ST_ENTER  = 6'b000010,
      ST_STBY   = 6'b000100,
      ST_SETTLE = 6'b001000,
      ST_VHOLD  = 6'b010000,
      ST_DONE   = 6'b100000
   } lp_state_e;

   typedef enum logic {
      CAUSE_IRQ = 1'b0,
      CAUSE_RST = 1'b1
   } lp_cause_e;

   localparam int LP_MAP_POW2 = 0;
   localparam int LP_MAP_LIN  = 1;

endpackage

// File: rtl/lpwr_wake_qual.sv
`timescale 1ns/1ps
module lpwr_wake_qual #(
   parameter int NUM_IRQ = 12,
   parameter int NUM_AUX = 3
) (
   input  logic               nmi_i,
   input  logic [NUM_IRQ-1:0] irq_req_i,
   input  logic [NUM_IRQ-1:0] irq_en_i,
   input  logic [NUM_IRQ-1:0] irq_cpu_mask_i,
   input  logic [NUM_IRQ-1:0] irq_dma_trig_i,
   input  logic               hipri_pend_i,
   input  logic [NUM_AUX-1:0] aux_req_i,
   input  logic [NUM_AUX-1:0] aux_en_i,
   output logic               wake_any_o
);

   if (NUM_IRQ < 1 || NUM_IRQ > 32) begin : g_bad_irq
      $error("lpwr_wake_qual: NUM_IRQ must be 1..32");
   end
   if (NUM_AUX < 1 || NUM_AUX > 8) begin : g_bad_aux
      $error("lpwr_wake_qual: NUM_AUX must be 1..8");
   end

   logic [NUM_IRQ-1:0] irq_hit;
   logic [NUM_AUX-1:0] aux_hit;

   // Per-line qualification of the external interrupt lines
   for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      always_comb begin
         irq_hit[gi] = irq_req_i[gi] & irq_en_i[gi]
                     & ~irq_cpu_mask_i[gi] & ~irq_dma_trig_i[gi];
      end
   end

   for (genvar ga = 0; ga < NUM_AUX; ga++) begin : g_aux
      always_comb begin
         aux_hit[ga] = aux_req_i[ga] & aux_en_i[ga];
      end
   end

   always_comb begin
      wake_any_o = nmi_i | ((|irq_hit) & ~hipri_pend_i) | (|aux_hit);
   end

endmodule

// File: rtl/lpwr_settle_timer.sv
`timescale 1ns/1ps
module lpwr_settle_timer #(
   parameter int CNT_W      = 16,
   parameter int SEL_W      = 5,
   parameter int SETTLE_MAP = 0,
   parameter int LIN_SHIFT  = 4
) (
   input  logic             clk_i,
   input  logic             arst_n,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             done_o
);
   import lpwr_pkg::*;

   localparam int MAX_SHIFT = CNT_W - 1;

   if (CNT_W < 2 || CNT_W > 32 || CNT_W > (1 << SEL_W)) begin : g_bad_w
      $error("lpwr_settle_timer: CNT_W out of range");
   end
   if (SETTLE_MAP != LP_MAP_POW2 && SETTLE_MAP != LP_MAP_LIN) begin : g_bad_map
      $error("lpwr_settle_timer: unknown SETTLE_MAP");
   end
   if (SETTLE_MAP == LP_MAP_LIN && (SEL_W + 1 + LIN_SHIFT > CNT_W)) begin : g_bad_lin
      $error("lpwr_settle_timer: linear map overflows counter");
   end

   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] term_m1;
   logic [CNT_W-1:0] cnt;

   if (SETTLE_MAP == LP_MAP_POW2) begin : g_pow2
      logic [SEL_W-1:0] shamt;
      always_comb begin
         shamt = (sel_i > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel_i;
         term  = CNT_W'(1) << shamt;
      end
   end else begin : g_lin
      always_comb begin
         term = (CNT_W'(sel_i) + CNT_W'(1)) << LIN_SHIFT;
      end
   end

   always_comb begin
      term_m1 = term - CNT_W'(1);
   end

   always_ff @(posedge clk_i or negedge arst_n) begin
      if (!arst_n) begin
         cnt <= '0;
      end else if (!run_i) begin
         cnt <= '0;
      end else if (tick_i && (cnt != term_m1)) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   always_comb begin
      done_o = run_i & tick_i & (cnt == term_m1);
   end

   // R7
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      run_i |-> (cnt <= term_m1));

   // R7
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (run_i && !tick_i) |=> (!run_i || $stable(cnt)));

endmodule

// File: rtl/lpwr_fsm.sv
`timescale 1ns/1ps
module lpwr_fsm #(
   parameter int SEL_W = 5
) (
   input  logic                clk_i,
   input  logic                arst_n,
   input  logic                sleep_req_i,
   input  logic                stby_en_i,
   input  logic                deep_i,
   input  logic                wdt_mode_i,
   input  logic                bus_keep_i,
   input  logic [SEL_W-1:0]    settle_sel_i,
   input  logic                wake_any_i,
   input  logic                vmon_rst_i,
   input  logic                settle_done_i,
   output lpwr_pkg::lp_state_e state_o,
   output lpwr_pkg::lp_cause_e cause_o,
   output logic [SEL_W-1:0]    sel_lat_o,
   output logic                keep_lat_o
);
   import lpwr_pkg::*;

   lp_state_e state_q, state_d;
   lp_cause_e cause_q, cause_d;
   logic      accept;

   always_comb begin
      accept = sleep_req_i & stby_en_i & ~deep_i & ~wdt_mode_i;
   end

   always_comb begin
      state_d = state_q;
      cause_d = cause_q;
      case (state_q)
         ST_RUN: begin
            if (accept) state_d = ST_ENTER;
         end
         ST_ENTER: begin
            if (wake_any_i || vmon_rst_i) state_d = ST_RUN;
            else                          state_d = ST_STBY;
         end
         ST_STBY: begin
            if (vmon_rst_i)      state_d = ST_VHOLD;
            else if (wake_any_i) state_d = ST_SETTLE;
         end
         ST_SETTLE: begin
            if (vmon_rst_i) begin
               state_d = ST_VHOLD;
            end else if (settle_done_i) begin
               state_d = ST_DONE;
               cause_d = CAUSE_IRQ;
            end
         end
         ST_VHOLD: begin
            if (!vmon_rst_i) begin
               state_d = ST_DONE;
               cause_d = CAUSE_RST;
            end
         end
         ST_DONE: state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge arst_n) begin
      if (!arst_n) begin
         state_q    <= ST_RUN;
         cause_q    <= CAUSE_IRQ;
         sel_lat_o  <= '0;
         keep_lat_o <= 1'b0;
      end else begin
         state_q <= state_d;
         cause_q <= cause_d;
         if (state_q == ST_RUN && accept) begin
            sel_lat_o  <= settle_sel_i;
            keep_lat_o <= bus_keep_i;
         end
      end
   end

   assign state_o = state_q;
   assign cause_o = cause_q;

   // R1
   state_onehot_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      $countones(state_q) == 1);

   // R2
   wdt_block_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (state_q == ST_RUN && wdt_mode_i) |=> (state_q != ST_ENTER));

   // R3
   cfg_block_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (state_q == ST_RUN && (deep_i || !stby_en_i)) |=> (state_q != ST_ENTER));

   // R10
   entry_abort_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (state_q == ST_ENTER && (wake_any_i || vmon_rst_i)) |=> (state_q == ST_RUN));

   // R9
   vhold_stay_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (state_q == ST_VHOLD && vmon_rst_i) |=> (state_q == ST_VHOLD));

   // R8
   irq_done_src_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (state_q == ST_DONE && cause_q == CAUSE_IRQ) |-> ($past(state_q) == ST_SETTLE));

   // R9
   rst_done_src_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (state_q == ST_DONE && cause_q == CAUSE_RST)
         |-> ($past(state_q) == ST_VHOLD && !$past(vmon_rst_i)));

endmodule

// File: rtl/lpwr_standby_ctrl.sv
`timescale 1ns/1ps
module lpwr_standby_ctrl #(
   parameter int NUM_IRQ    = 12,
   parameter int NUM_AUX    = 3,
   parameter int SEL_W      = 5,
   parameter int CNT_W      = 16,
   parameter int SETTLE_MAP = 0,
   parameter int LIN_SHIFT  = 4
) (
   input  logic               clk_i,
   input  logic               rst_n_i,
   input  logic               stby_pin_n_i,
   input  logic               lf_tick_i,
   input  logic               sleep_req_i,
   input  logic               cfg_stby_en_i,
   input  logic               cfg_deep_i,
   input  logic               cfg_bus_keep_i,
   input  logic [SEL_W-1:0]   cfg_settle_sel_i,
   input  logic               wdt_mode_i,
   input  logic               nmi_i,
   input  logic [NUM_IRQ-1:0] irq_req_i,
   input  logic [NUM_IRQ-1:0] irq_en_i,
   input  logic [NUM_IRQ-1:0] irq_cpu_mask_i,
   input  logic [NUM_IRQ-1:0] irq_dma_trig_i,
   input  logic               hipri_pend_i,
   input  logic [NUM_AUX-1:0] aux_req_i,
   input  logic [NUM_AUX-1:0] aux_en_i,
   input  logic               vmon_rst_i,
   output logic               osc_en_o,
   output logic               cpu_clk_en_o,
   output logic               per_clk_en_o,
   output logic               bus_hiz_o,
   output logic               bus_hold_o,
   output logic               irq_wake_o,
   output logic               rst_wake_o
);
   import lpwr_pkg::*;

   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
      $error("lpwr_standby_ctrl: SEL_W must be 1..8");
   end

   logic             arst_n;
   logic             wake_any;
   logic             settle_done;
   logic             settle_run;
   logic             keep_lat;
   logic [SEL_W-1:0] sel_lat;
   lp_state_e        state;
   lp_cause_e        cause;
   logic             clocks_off;

   // Either pin forces the run state
   assign arst_n = rst_n_i & stby_pin_n_i;

   lpwr_wake_qual #(
      .NUM_IRQ (NUM_IRQ),
      .NUM_AUX (NUM_AUX)
   ) u_qual (
      .nmi_i          (nmi_i),
      .irq_req_i      (irq_req_i),
      .irq_en_i       (irq_en_i),
      .irq_cpu_mask_i (irq_cpu_mask_i),
      .irq_dma_trig_i (irq_dma_trig_i),
      .hipri_pend_i   (hipri_pend_i),
      .aux_req_i      (aux_req_i),
      .aux_en_i       (aux_en_i),
      .wake_any_o     (wake_any)
   );

   lpwr_fsm #(
      .SEL_W (SEL_W)
   ) u_fsm (
      .clk_i         (clk_i),
      .arst_n        (arst_n),
      .sleep_req_i   (sleep_req_i),
      .stby_en_i     (cfg_stby_en_i),
      .deep_i        (cfg_deep_i),
      .wdt_mode_i    (wdt_mode_i),
      .bus_keep_i    (cfg_bus_keep_i),
      .settle_sel_i  (cfg_settle_sel_i),
      .wake_any_i    (wake_any),
      .vmon_rst_i    (vmon_rst_i),
      .settle_done_i (settle_done),
      .state_o       (state),
      .cause_o       (cause),
      .sel_lat_o     (sel_lat),
      .keep_lat_o    (keep_lat)
   );

   assign settle_run = (state == ST_SETTLE);

   lpwr_settle_timer #(
      .CNT_W      (CNT_W),
      .SEL_W      (SEL_W),
      .SETTLE_MAP (SETTLE_MAP),
      .LIN_SHIFT  (LIN_SHIFT)
   ) u_timer (
      .clk_i  (clk_i),
      .arst_n (arst_n),
      .run_i  (settle_run),
      .tick_i (lf_tick_i),
      .sel_i  (sel_lat),
      .done_o (settle_done)
   );

   // Output decode from the one-hot state
   always_comb begin
      clocks_off   = (state == ST_STBY) || (state == ST_SETTLE);
      osc_en_o     = (state != ST_STBY);
      cpu_clk_en_o = !clocks_off;
      per_clk_en_o = !clocks_off;
      bus_hiz_o    = clocks_off && !keep_lat;
      bus_hold_o   = clocks_off && keep_lat;
      irq_wake_o   = (state == ST_DONE) && (cause == CAUSE_IRQ);
      rst_wake_o   = (state == ST_DONE) && (cause == CAUSE_RST);
   end

   // R4
   clk_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      !osc_en_o |-> (!cpu_clk_en_o && !per_clk_en_o));

   // R5
   bus_excl_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      !(bus_hiz_o && bus_hold_o));

   // R5
   bus_when_gated_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      (bus_hiz_o || bus_hold_o) |-> !cpu_clk_en_o);

   // R8
   pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!arst_n)
      !(irq_wake_o && rst_wake_o));

endmodule

// File: tb/lpwr_standby_ctrl_bench.sv
`timescale 1ns/1ps
module lpwr_standby_ctrl_bench;
   localparam int NI = 12;
   localparam int NA = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0, stby_n = 1'b1, lf_tick = 1'b1;
   logic          sleep = 1'b0, stby_en = 1'b1, deep = 1'b0, keep = 1'b0;
   logic [4:0]    sel = '0;
   logic          wdt = 1'b0, nmi = 1'b0, hipri = 1'b0, vmon = 1'b0;
   logic [NI-1:0] irq_req = '0, irq_en = '0, irq_mask = '0, irq_dma = '0;
   logic [NA-1:0] aux_req = '0, aux_en = '0;
   logic          osc_en, cpu_clk, per_clk, bus_hiz, bus_hold, irq_wake, rst_wake;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   lpwr_standby_ctrl u_lpwr_standby_ctrl (
      .clk_i (clk), .rst_n_i (rst_n), .stby_pin_n_i (stby_n), .lf_tick_i (lf_tick),
      .sleep_req_i (sleep), .cfg_stby_en_i (stby_en), .cfg_deep_i (deep),
      .cfg_bus_keep_i (keep), .cfg_settle_sel_i (sel), .wdt_mode_i (wdt),
      .nmi_i (nmi), .irq_req_i (irq_req), .irq_en_i (irq_en),
      .irq_cpu_mask_i (irq_mask), .irq_dma_trig_i (irq_dma), .hipri_pend_i (hipri),
      .aux_req_i (aux_req), .aux_en_i (aux_en), .vmon_rst_i (vmon),
      .osc_en_o (osc_en), .cpu_clk_en_o (cpu_clk), .per_clk_en_o (per_clk),
      .bus_hiz_o (bus_hiz), .bus_hold_o (bus_hold),
      .irq_wake_o (irq_wake), .rst_wake_o (rst_wake)
   );

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
      end
   endtask

   task automatic chk_run(string what);
      chk({what, " osc"}, int'(osc_en), 1);
      chk({what, " cpu clk"}, int'(cpu_clk), 1);
      chk({what, " irq pulse"}, int'(irq_wake), 0);
      chk({what, " rst pulse"}, int'(rst_wake), 0);
   endtask

   // Returns at a negedge with the block in standby
   task automatic enter_stby();
      @(negedge clk) sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      @(negedge clk);
   endtask

   task automatic settle_measure(int exp_t, int exp_keep, string tag);
      int n = 0;
      nmi = 1'b1;
      @(negedge clk) nmi = 1'b0;
      chk({"R7 osc back ", tag}, int'(osc_en), 1);
      chk({"R5 hiz ", tag}, int'(bus_hiz), 1 - exp_keep);
      chk({"R5 hold ", tag}, int'(bus_hold), exp_keep);
      while (osc_en && !cpu_clk && n < 40000) begin
         n++;
         @(negedge clk);
      end
      chk({"R7 settle length ", tag}, n, exp_t);
      chk({"R8 irq pulse ", tag}, int'(irq_wake), 1);
      chk({"R8 no rst pulse ", tag}, int'(rst_wake), 0);
      @(negedge clk);
      chk({"R8 pulse ends ", tag}, int'(irq_wake), 0);
   endtask

   task automatic back_to_run();
      if (!osc_en) begin
         nmi = 1'b1;
         @(negedge clk) nmi = 1'b0;
      end
      while (!cpu_clk) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog expired: act=%0d exp=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk_run("R11 reset");
      chk("R11 reset hiz", int'(bus_hiz), 0);
      chk("R11 reset hold", int'(bus_hold), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 entry cycle, R4 standby outputs
      sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      chk("R1 entry cycle clocks on", int'(cpu_clk), 1);
      chk("R1 entry cycle osc on", int'(osc_en), 1);
      @(negedge clk);
      chk("R4 osc off", int'(osc_en), 0);
      chk("R4 cpu clk off", int'(cpu_clk), 0);
      chk("R4 per clk off", int'(per_clk), 0);
      chk("R5 hiz in standby", int'(bus_hiz), 1);
      repeat (8) @(negedge clk);
      chk("R4 osc stays off", int'(osc_en), 0);
      settle_measure(1, 0, "first");

      // R7 sweep of settle select with alternating bus mode
      for (int s = 0; s < 10; s++) begin
         sel = 5'(s);
         keep = 1'(s % 2);
         enter_stby();
         chk("R4 standby in sweep", int'(osc_en), 0);
         settle_measure(1 << s, s % 2, "sweep");
      end
      sel = 5'd31;
      keep = 1'b0;
      enter_stby();
      settle_measure(1 << 15, 0, "clip");

      // R5/R7 capture at acceptance
      sel = 5'd2;
      @(negedge clk) sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      sel = 5'd9;
      keep = 1'b1;
      @(negedge clk);
      settle_measure(4, 0, "captured");
      sel = '0;
      keep = 1'b0;

      // R7 counter frozen without reference ticks
      sel = 5'd3;
      lf_tick = 1'b0;
      enter_stby();
      nmi = 1'b1;
      @(negedge clk) nmi = 1'b0;
      repeat (30) @(negedge clk);
      chk("R7 no tick still settling", int'(cpu_clk), 0);
      chk("R7 no tick osc on", int'(osc_en), 1);
      lf_tick = 1'b1;
      begin
         int n = 0;
         while (!cpu_clk && n < 100) begin
            n++;
            @(negedge clk);
         end
         chk("R7 length after ticks resume", n, 8);
      end
      chk("R8 pulse after frozen settle", int'(irq_wake), 1);
      @(negedge clk);
      sel = '0;

      // R2 watchdog blocks entry
      wdt = 1'b1;
      sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk_run("R2 watchdog mode");
      end
      wdt = 1'b0;

      // R3 deep standby select and cleared enable
      deep = 1'b1;
      sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      repeat (2) @(negedge clk);
      chk_run("R3 deep select");
      deep = 1'b0;
      stby_en = 1'b0;
      sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      repeat (2) @(negedge clk);
      chk_run("R3 enable cleared");
      stby_en = 1'b1;

      // R12 wake inputs in run
      nmi = 1'b1;
      irq_en = '1;
      irq_req = '1;
      aux_en = '1;
      aux_req = '1;
      vmon = 1'b1;
      @(negedge clk);
      nmi = 1'b0;
      irq_req = '0;
      aux_req = '0;
      vmon = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk_run("R12 wake in run");
         @(negedge clk);
      end
      irq_en = '0;
      aux_en = '0;

      // R6 interrupt qualification matrix
      for (int i = 0; i < NI; i++) begin
         for (int c = 0; c < 16; c++) begin
            logic [NI-1:0] one;
            int exp_w;
            one = NI'(1) << i;
            irq_en = c[0] ? '1 : ~one;
            irq_mask = c[1] ? one : '0;
            irq_dma = c[2] ? one : '0;
            hipri = c[3];
            exp_w = (c == 1) ? 1 : 0;
            enter_stby();
            irq_req = one;
            @(negedge clk) irq_req = '0;
            chk("R6 irq line wake", int'(osc_en), exp_w);
            irq_en = '0;
            irq_mask = '0;
            irq_dma = '0;
            hipri = 1'b0;
            back_to_run();
         end
      end

      // R6 auxiliary sources
      for (int a = 0; a < NA; a++) begin
         for (int e = 0; e < 2; e++) begin
            logic [NA-1:0] one;
            one = NA'(1) << a;
            aux_en = (e == 1) ? one : ~one;
            enter_stby();
            aux_req = one;
            @(negedge clk) aux_req = '0;
            chk("R6 aux wake", int'(osc_en), e);
            aux_en = '0;
            back_to_run();
         end
      end

      // R6 NMI ignores pending priority and masks
      irq_mask = '1;
      hipri = 1'b1;
      enter_stby();
      nmi = 1'b1;
      @(negedge clk) nmi = 1'b0;
      chk("R6 nmi wakes despite pending", int'(osc_en), 1);
      hipri = 1'b0;
      irq_mask = '0;
      back_to_run();

      // R10 abort in entry cycle by nmi, then by voltage monitor
      sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      nmi = 1'b1;
      chk("R10 entry clocks on", int'(cpu_clk), 1);
      @(negedge clk) nmi = 1'b0;
      chk_run("R10 nmi abort");
      @(negedge clk);
      chk_run("R10 nmi abort stays run");
      sleep = 1'b1;
      @(negedge clk) sleep = 1'b0;
      vmon = 1'b1;
      @(negedge clk) vmon = 1'b0;
      chk_run("R10 vmon abort");
      @(negedge clk);
      chk_run("R10 vmon abort stays run");

      // R9 voltage reset in standby
      enter_stby();
      vmon = 1'b1;
      @(negedge clk);
      chk("R9 osc on at once", int'(osc_en), 1);
      chk("R9 cpu clk on at once", int'(cpu_clk), 1);
      chk("R9 per clk on at once", int'(per_clk), 1);
      repeat (5) @(negedge clk);
      chk("R9 held no rst pulse", int'(rst_wake), 0);
      chk("R9 held no irq pulse", int'(irq_wake), 0);
      vmon = 1'b0;
      @(negedge clk);
      chk("R9 rst pulse", int'(rst_wake), 1);
      chk("R9 no irq pulse", int'(irq_wake), 0);
      @(negedge clk);
      chk("R9 rst pulse ends", int'(rst_wake), 0);

      // R9 voltage reset during settle
      sel = 5'd6;
      enter_stby();
      nmi = 1'b1;
      @(negedge clk) nmi = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 settling before vmon", int'(cpu_clk), 0);
      vmon = 1'b1;
      @(negedge clk);
      chk("R9 settle cut clocks on", int'(cpu_clk), 1);
      chk("R9 settle cut no irq", int'(irq_wake), 0);
      vmon = 1'b0;
      @(negedge clk);
      chk("R9 settle cut rst pulse", int'(rst_wake), 1);
      chk("R9 settle cut irq", int'(irq_wake), 0);
      @(negedge clk);
      sel = '0;

      // R11 standby pin in standby, reset pin in settle
      enter_stby();
      stby_n = 1'b0;
      #1;
      chk("R11 stby pin osc", int'(osc_en), 1);
      chk("R11 stby pin clocks", int'(cpu_clk), 1);
      chk("R11 stby pin hiz", int'(bus_hiz), 0);
      @(negedge clk) stby_n = 1'b1;
      @(negedge clk);
      chk_run("R11 after stby pin");
      sel = 5'd6;
      enter_stby();
      nmi = 1'b1;
      @(negedge clk) nmi = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_run("R11 reset pin in settle");
      @(negedge clk) rst_n = 1'b1;
      sel = '0;
      @(negedge clk);
      enter_stby();
      chk("R11 entry works after reset", int'(osc_en), 0);
      back_to_run();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule